// File: doc/BRIEF.md
# Octal PSRAM Mode Register Configurator

This block runs the power-up configuration of an octal pseudo-static RAM. It sits above a transaction engine that moves command, address, dummy and data phases on the memory bus. For each step the configurator issues one request (read or write, register address, data length in bits, dummy on or off), then waits for the engine's completion pulse before it moves on. A start pulse launches the whole sequence. It can be launched again once the sequence has finished.

The sequence first fetches mode registers 0 and 1. It rewrites register 0 with new drive-strength, latency-code and fixed-latency fields and leaves its top two bits unchanged, then writes both bytes back. It then reads back registers 0 to 4 and register 8. The vendor code in register 1 decides whether a device is present. The density code in register 2 becomes a byte size. Derived fields (read latency in cycles, write latency code, burst length and type) are presented next to the captured register bytes.

Top module: `psram_mr_cfg`

## Requirements
- R1: After reset, `busy`, `done`, `present` and `req_valid` are 0, `size_bytes` is 0 and every captured register output is 0.
- R2: A `start` pulse is accepted only while the block is idle or done, and it is ignored while `busy` is 1. The first request it causes is a read at address 0, 16 bits long, with `req_dummy` = 1. All reads carry `req_dummy` = 1.
- R3: `req_valid` is a one-cycle pulse, and no new request is issued before `rsp_done` answers the previous one. An `rsp_done` pulse that arrives while no request is pending has no effect.
- R4: The second request is a write (`req_write` = 1) at address 0, 16 bits long, with `req_dummy` = 0. `req_wdata[15:8]` is register 1 as fetched. `req_wdata[7:0]` is register 0 as fetched, with bits 1:0 replaced by 0, bits 4:2 by 2, bit 5 by 1, and bits 7:6 kept.
- R5: Readback issues reads in the order address 0x0 (16 bits), 0x2 (16 bits), 0x4 (8 bits), 0x8 (8 bits). A 16-bit response holds the lower-addressed register in `rsp_rdata[7:0]` and the next one in `rsp_rdata[15:8]`. An 8-bit response uses `rsp_rdata[7:0]` only. The readback values appear on `mr0`..`mr4` and `mr8`.
- R6: If bits 4:0 of register 1 read back as 0xD, `present` = 1. Otherwise, no request follows the readback at address 0x0, and the block finishes with `present` = 0 and `size_bytes` = 0. `present` is only ever 1 while `done` is 1.
- R7: With a device present, `size_bytes` follows the density code in register 2 bits 2:0: 0 gives 2 MiB, 1 gives 4 MiB, 3 gives 8 MiB, 5 gives 16 MiB, 7 gives 32 MiB, and any other code gives 0.
- R8: `rd_lat_cycles` equals twice register 0 bits 4:2 plus 6.
- R9: `burst_len` is register 8 bits 1:0, `burst_type` is register 8 bit 2, and `wr_lat_code` is register 4 bits 7:5.
- R10: `done` stays 1 after completion until the next accepted `start`, and it falls in the cycle after that start. `done` and `busy` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle launch pulse |
| req_valid | output | 1 | Request pulse to the transaction engine |
| req_write | output | 1 | 1 = register write, 0 = register read |
| req_addr | output | ADDR_W | Register address of the request |
| req_bits | output | 5 | Data phase length in bits (8 or 16) |
| req_dummy | output | 1 | 1 when the request uses the read dummy phase |
| req_wdata | output | 16 | Write data, register 0 in the low byte |
| rsp_done | input | 1 | Completion pulse from the transaction engine |
| rsp_rdata | input | 16 | Read data, valid with rsp_done |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished |
| present | output | 1 | Vendor code matched |
| size_bytes | output | SIZE_W | Decoded device size in bytes |
| mr0 | output | 8 | Register 0 readback |
| mr1 | output | 8 | Register 1 readback |
| mr2 | output | 8 | Register 2 readback |
| mr3 | output | 8 | Register 3 readback |
| mr4 | output | 8 | Register 4 readback |
| mr8 | output | 8 | Register 8 readback |
| rd_lat_cycles | output | 5 | Read latency in clock cycles |
| wr_lat_code | output | 3 | Write latency code |
| burst_len | output | 2 | Burst length code |
| burst_type | output | 1 | Burst type bit |

## Verification
The assertions assume the transaction engine returns exactly one `rsp_done` per request, at least one cycle after `req_valid`. They also assume `start` is a single-cycle pulse. The bench responder watches each request at the falling edge and answers after a chosen latency of one or more cycles. It drives stray completions and a mid-sequence start only while no request is pending, so the one-outstanding-request property stays meaningful.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

  localparam int unsigned MRC_STEPS  = 6;
  localparam int unsigned MRC_STEP_W = 3;
  localparam int unsigned MRC_DATA_W = 16;

  // step indices; their order is the configuration sequence
  localparam logic [MRC_STEP_W-1:0] STEP_FETCH = 3'd0;
  localparam logic [MRC_STEP_W-1:0] STEP_PROG  = 3'd1;
  localparam logic [MRC_STEP_W-1:0] STEP_RB01  = 3'd2;
  localparam logic [MRC_STEP_W-1:0] STEP_RB23  = 3'd3;
  localparam logic [MRC_STEP_W-1:0] STEP_RB4   = 3'd4;
  localparam logic [MRC_STEP_W-1:0] STEP_RB8   = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_EVAL  = 3'd3,
    ST_DONE  = 3'd4
  } mrc_state_t;

  typedef struct packed {
    logic       wr;
    logic       dummy;
    logic [3:0] addr;
    logic [4:0] bits;
  } mrc_step_t;

  function automatic mrc_step_t mrc_step_desc(input logic [MRC_STEP_W-1:0] idx);
    mrc_step_t d;
    d.wr    = 1'b0;
    d.dummy = 1'b1;
    d.addr  = 4'h0;
    d.bits  = 5'd16;
    case (idx)
      STEP_PROG: begin d.wr = 1'b1; d.dummy = 1'b0; end
      STEP_RB23: d.addr = 4'h2;
      STEP_RB4:  begin d.addr = 4'h4; d.bits = 5'd8; end
      STEP_RB8:  begin d.addr = 4'h8; d.bits = 5'd8; end
      default:   ;
    endcase
    return d;
  endfunction

  function automatic logic [7:0] mrc_patch_mr0(input logic [7:0] orig,
                                               input logic [1:0] drv,
                                               input logic [2:0] lat,
                                               input logic       fix);
    return {orig[7:6], fix, lat, drv};
  endfunction

  function automatic logic [31:0] mrc_density_bytes(input logic [2:0] code);
    logic [31:0] b;
    case (code)
      3'd0:    b = 32'h0020_0000;
      3'd1:    b = 32'h0040_0000;
      3'd3:    b = 32'h0080_0000;
      3'd5:    b = 32'h0100_0000;
      3'd7:    b = 32'h0200_0000;
      default: b = 32'h0;
    endcase
    return b;
  endfunction

  function automatic logic [4:0] mrc_rd_lat_cycles(input logic [2:0] code);
    return {1'b0, code, 1'b0} + 5'd6;
  endfunction

endpackage

// File: rtl/mrc_step_sequencer.sv
module mrc_step_sequencer
  import mrc_pkg::*;
#(
  parameter int unsigned STEPS = MRC_STEPS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  rsp_done,
  input  logic                  abort,
  output logic                  launch,
  output logic                  issue,
  output logic                  accept,
  output logic                  eval,
  output logic [MRC_STEP_W-1:0] step,
  output logic                  busy,
  output logic                  done
);

  localparam logic [MRC_STEP_W-1:0] LAST = MRC_STEP_W'(STEPS - 1);

  mrc_state_t st;
  logic       last_step;

  assign last_step = (step == LAST);
  assign launch    = start && ((st == ST_IDLE) || (st == ST_DONE));
  assign issue     = (st == ST_ISSUE);
  assign accept    = (st == ST_WAIT) && rsp_done;
  assign eval      = (st == ST_EVAL);
  assign busy      = (st == ST_ISSUE) || (st == ST_WAIT) || (st == ST_EVAL);
  assign done      = (st == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      step <= '0;
    end else begin
      case (st)
        ST_IDLE, ST_DONE: begin
          if (launch) begin
            st   <= ST_ISSUE;
            step <= '0;
          end
        end
        ST_ISSUE: st <= ST_WAIT;
        ST_WAIT: begin
          if (rsp_done) begin
            if (abort || last_step) begin
              st <= ST_EVAL;
            end else begin
              st   <= ST_ISSUE;
              step <= step + 1'b1;
            end
          end
        end
        ST_EVAL: st <= ST_DONE;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mrc_reg_capture.sv
module mrc_reg_capture
  import mrc_pkg::*;
#(
  parameter logic [1:0] DRV_CODE  = 2'd0,
  parameter logic [2:0] LAT_CODE  = 3'd2,
  parameter logic       FIXED_LAT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  accept,
  input  logic [MRC_STEP_W-1:0] step,
  input  logic [MRC_DATA_W-1:0] rdata,
  output logic [MRC_DATA_W-1:0] wdata,
  output logic [7:0]            mr0,
  output logic [7:0]            mr1,
  output logic [7:0]            mr2,
  output logic [7:0]            mr3,
  output logic [7:0]            mr4,
  output logic [7:0]            mr8
);

  localparam int unsigned NSLOT = 6;

  // slot i is loaded by this step
  function automatic logic [MRC_STEP_W-1:0] slot_step(input int i);
    case (i)
      0, 1:    return STEP_RB01;
      2, 3:    return STEP_RB23;
      4:       return STEP_RB4;
      default: return STEP_RB8;
    endcase
  endfunction

  // slot i takes the upper byte lane
  function automatic logic slot_hi(input int i);
    return (i == 1) || (i == 3);
  endfunction

  logic [NSLOT*8-1:0] slot_bus;
  logic [7:0]         fetch_lo;
  logic [7:0]         fetch_hi;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (clear) begin
        q <= '0;
      end else if (accept && (step == slot_step(g))) begin
        q <= slot_hi(g) ? rdata[15:8] : rdata[7:0];
      end
    end
    assign slot_bus[g*8 +: 8] = q;
  end

  // register 0/1 as first fetched, kept for the write-back
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_lo <= '0;
      fetch_hi <= '0;
    end else if (clear) begin
      fetch_lo <= '0;
      fetch_hi <= '0;
    end else if (accept && (step == STEP_FETCH)) begin
      fetch_lo <= rdata[7:0];
      fetch_hi <= rdata[15:8];
    end
  end

  assign wdata = {fetch_hi, mrc_patch_mr0(fetch_lo, DRV_CODE, LAT_CODE, FIXED_LAT)};

  assign mr0 = slot_bus[7:0];
  assign mr1 = slot_bus[15:8];
  assign mr2 = slot_bus[23:16];
  assign mr3 = slot_bus[31:24];
  assign mr4 = slot_bus[39:32];
  assign mr8 = slot_bus[47:40];

endmodule

// File: rtl/mrc_identify.sv
module mrc_identify
  import mrc_pkg::*;
#(
  parameter int unsigned SIZE_W    = 32,
  parameter logic [4:0]  VENDOR_ID = 5'h0D
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  accept,
  input  logic [MRC_STEP_W-1:0] step,
  input  logic [MRC_DATA_W-1:0] rdata,
  input  logic                  eval,
  input  logic [7:0]            mr1,
  input  logic [7:0]            mr2,
  output logic                  abort,
  output logic                  present,
  output logic [SIZE_W-1:0]     size_bytes
);

  logic vendor_ok;

  assign abort     = accept && (step == STEP_RB01) && (rdata[12:8] != VENDOR_ID);
  assign vendor_ok = (mr1[4:0] == VENDOR_ID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present    <= 1'b0;
      size_bytes <= '0;
    end else if (clear) begin
      present    <= 1'b0;
      size_bytes <= '0;
    end else if (eval) begin
      present    <= vendor_ok;
      size_bytes <= vendor_ok ? SIZE_W'(mrc_density_bytes(mr2[2:0])) : '0;
    end
  end

endmodule

// File: rtl/psram_mr_cfg.sv
module psram_mr_cfg
  import mrc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SIZE_W    = 32,
  parameter logic [4:0]  VENDOR_ID = 5'h0D,
  parameter logic [1:0]  DRV_CODE  = 2'd0,
  parameter logic [2:0]  LAT_CODE  = 3'd2,
  parameter logic        FIXED_LAT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [4:0]        req_bits,
  output logic              req_dummy,
  output logic [15:0]       req_wdata,
  input  logic              rsp_done,
  input  logic [15:0]       rsp_rdata,
  output logic              busy,
  output logic              done,
  output logic              present,
  output logic [SIZE_W-1:0] size_bytes,
  output logic [7:0]        mr0,
  output logic [7:0]        mr1,
  output logic [7:0]        mr2,
  output logic [7:0]        mr3,
  output logic [7:0]        mr4,
  output logic [7:0]        mr8,
  output logic [4:0]        rd_lat_cycles,
  output logic [2:0]        wr_lat_code,
  output logic [1:0]        burst_len,
  output logic              burst_type
);

  logic                  launch;
  logic                  accept;
  logic                  eval;
  logic                  abort;
  logic [MRC_STEP_W-1:0] step;
  mrc_step_t             desc;

  mrc_step_sequencer #(.STEPS(MRC_STEPS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rsp_done (rsp_done),
    .abort    (abort),
    .launch   (launch),
    .issue    (req_valid),
    .accept   (accept),
    .eval     (eval),
    .step     (step),
    .busy     (busy),
    .done     (done)
  );

  mrc_reg_capture #(
    .DRV_CODE  (DRV_CODE),
    .LAT_CODE  (LAT_CODE),
    .FIXED_LAT (FIXED_LAT)
  ) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (launch),
    .accept (accept),
    .step   (step),
    .rdata  (rsp_rdata),
    .wdata  (req_wdata),
    .mr0    (mr0),
    .mr1    (mr1),
    .mr2    (mr2),
    .mr3    (mr3),
    .mr4    (mr4),
    .mr8    (mr8)
  );

  mrc_identify #(
    .SIZE_W    (SIZE_W),
    .VENDOR_ID (VENDOR_ID)
  ) u_id (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (launch),
    .accept     (accept),
    .step       (step),
    .rdata      (rsp_rdata),
    .eval       (eval),
    .mr1        (mr1),
    .mr2        (mr2),
    .abort      (abort),
    .present    (present),
    .size_bytes (size_bytes)
  );

  assign desc      = mrc_step_desc(step);
  assign req_write = desc.wr;
  assign req_addr  = ADDR_W'(desc.addr);
  assign req_bits  = desc.bits;
  assign req_dummy = desc.dummy;

  assign rd_lat_cycles = mrc_rd_lat_cycles(mr0[4:2]);
  assign wr_lat_code   = mr4[7:5];
  assign burst_len     = mr8[1:0];
  assign burst_type    = mr8[2];

endmodule

// File: rtl/mrc_checker.sv
module mrc_checker #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SIZE_W    = 32,
  parameter logic [4:0]  VENDOR_ID = 5'h0D
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [4:0]        req_bits,
  input logic              req_dummy,
  input logic              rsp_done,
  input logic              busy,
  input logic              done,
  input logic              present,
  input logic [SIZE_W-1:0] size_bytes,
  input logic [7:0]        mr1
);

  logic pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pending <= 1'b0;
    else if (req_valid) pending <= 1'b1;
    else if (rsp_done)  pending <= 1'b0;
  end

  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  // R3
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !pending);

  // R4
  write_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> (req_addr == '0 && req_bits == 5'd16 && !req_dummy));

  // R2
  read_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |-> req_dummy);

  // R6
  present_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    present |-> done);

  // R6
  vendor_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(present) |-> (mr1[4:0] == VENDOR_ID));

  // R7
  size_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size_bytes != '0) |-> present);

  // R10
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind psram_mr_cfg mrc_checker #(
  .ADDR_W    (ADDR_W),
  .SIZE_W    (SIZE_W),
  .VENDOR_ID (VENDOR_ID)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_bits   (req_bits),
  .req_dummy  (req_dummy),
  .rsp_done   (rsp_done),
  .busy       (busy),
  .done       (done),
  .present    (present),
  .size_bytes (size_bytes),
  .mr1        (mr1)
);

// File: tb/psram_mr_cfg_tb.sv
module psram_mr_cfg_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        req_valid, req_write, req_dummy;
  logic [31:0] req_addr;
  logic [4:0]  req_bits;
  logic [15:0] req_wdata;
  logic        rsp_done;
  logic [15:0] rsp_rdata = 16'h0;
  logic        busy, done, present;
  logic [31:0] size_bytes;
  logic [7:0]  mr0, mr1, mr2, mr3, mr4, mr8;
  logic [4:0]  rd_lat_cycles;
  logic [2:0]  wr_lat_code;
  logic [1:0]  burst_len;
  logic        burst_type;

  logic resp_pulse = 1'b0;
  logic stray_pulse = 1'b0;
  assign rsp_done = resp_pulse | stray_pulse;

  always #4 clk = ~clk;

  psram_mr_cfg u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_bits(req_bits), .req_dummy(req_dummy), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .busy(busy), .done(done), .present(present), .size_bytes(size_bytes),
    .mr0(mr0), .mr1(mr1), .mr2(mr2), .mr3(mr3), .mr4(mr4), .mr8(mr8),
    .rd_lat_cycles(rd_lat_cycles), .wr_lat_code(wr_lat_code),
    .burst_len(burst_len), .burst_type(burst_type)
  );

  int n_chk = 0;
  int n_err = 0;
  int resp_lat = 1;

  logic [7:0]  mem [0:8];
  int          req_cnt = 0;
  logic [31:0] log_addr  [0:15];
  logic        log_wr    [0:15];
  logic [4:0]  log_bits  [0:15];
  logic        log_dummy [0:15];
  logic [15:0] log_wdata [0:15];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural memory-side responder
  initial begin
    forever begin
      @(negedge clk);
      resp_pulse = 1'b0;
      if (rst_n && req_valid) begin
        if (req_cnt < 16) begin
          log_addr[req_cnt]  = req_addr;
          log_wr[req_cnt]    = req_write;
          log_bits[req_cnt]  = req_bits;
          log_dummy[req_cnt] = req_dummy;
          log_wdata[req_cnt] = req_wdata;
        end
        req_cnt++;
        if (req_write) begin
          mem[0] = req_wdata[7:0];
          mem[1] = req_wdata[15:8];
        end
        repeat (resp_lat) @(negedge clk);
        if (req_write) rsp_rdata = 16'h0;
        else if (req_bits == 5'd16) rsp_rdata = {mem[req_addr[3:0] + 1], mem[req_addr[3:0]]};
        else rsp_rdata = {8'hFF, mem[req_addr[3:0]]};
        resp_pulse = 1'b1;
      end
    end
  end

  task automatic set_model(input logic [7:0] a0, a1, a2, a3, a4, a8);
    for (int i = 0; i < 9; i++) mem[i] = 8'h00;
    mem[0] = a0; mem[1] = a1; mem[2] = a2; mem[3] = a3; mem[4] = a4; mem[8] = a8;
    req_cnt = 0;
  endtask

  function automatic logic [31:0] exp_size(input logic [2:0] c);
    if (c == 3'd0) return 32'd2 << 20;
    if (c == 3'd1) return 32'd4 << 20;
    if (c == 3'd3) return 32'd8 << 20;
    if (c == 3'd5) return 32'd16 << 20;
    if (c == 3'd7) return 32'd32 << 20;
    return 32'd0;
  endfunction

  task automatic run_seq(input string tag);
    int t;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk({tag, " R10 done cleared after start"}, {31'd0, done}, 32'd0);
    t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    chk({tag, " R10 sequence completes"}, {31'd0, done}, 32'd1);
  endtask

  task automatic t_reset();
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 present", {31'd0, present}, 32'd0);
    chk("R1 req_valid", {31'd0, req_valid}, 32'd0);
    chk("R1 size", size_bytes, 32'd0);
    chk("R1 regs", {mr0, mr1, mr2, mr3}, 32'd0);
    chk("R1 regs hi", {16'd0, mr4, mr8}, 32'd0);
  endtask

  task automatic t_stray();
    req_cnt = 0;
    @(negedge clk); stray_pulse = 1'b1;
    repeat (3) @(negedge clk);
    stray_pulse = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 stray rsp_done no request", req_cnt, 32'd0);
    chk("R3 stray rsp_done busy", {31'd0, busy}, 32'd0);
    chk("R3 stray rsp_done done", {31'd0, done}, 32'd0);
  endtask

  task automatic t_nominal();
    logic [31:0] ea [0:5] = '{32'h0, 32'h0, 32'h0, 32'h2, 32'h4, 32'h8};
    logic [4:0]  eb [0:5] = '{5'd16, 5'd16, 5'd16, 5'd16, 5'd8, 5'd8};
    resp_lat = 2;
    set_model(8'hC3, 8'hED, 8'h83, 8'h40, 8'hA5, 8'h07);
    run_seq("nominal");
    chk("R5 request count", req_cnt, 32'd6);
    for (int i = 0; i < 6; i++) begin
      chk($sformatf("R5 step %0d addr", i), log_addr[i], ea[i]);
      chk($sformatf("R5 step %0d bits", i), {27'd0, log_bits[i]}, {27'd0, eb[i]});
      chk($sformatf("R4 step %0d write flag", i), {31'd0, log_wr[i]}, (i == 1) ? 32'd1 : 32'd0);
      chk($sformatf("R2 step %0d dummy", i), {31'd0, log_dummy[i]}, (i == 1) ? 32'd0 : 32'd1);
    end
    // C3 -> keep 11, fixed=1, code=2, drive=0 -> E8
    chk("R4 write data", {16'd0, log_wdata[1]}, 32'h0000_EDE8);
    chk("R5 mr0..mr3", {mr0, mr1, mr2, mr3}, 32'hE8ED_8340);
    chk("R5 mr4 mr8", {16'd0, mr4, mr8}, 32'h0000_A507);
    chk("R6 present", {31'd0, present}, 32'd1);
    chk("R7 size 8MiB", size_bytes, 32'h0080_0000);
    chk("R8 read latency", {27'd0, rd_lat_cycles}, 32'd10);
    chk("R9 write latency", {29'd0, wr_lat_code}, 32'd5);
    chk("R9 burst length", {30'd0, burst_len}, 32'd3);
    chk("R9 burst type", {31'd0, burst_type}, 32'd1);
    chk("R10 busy low when done", {31'd0, busy}, 32'd0);
    repeat (4) @(negedge clk);
    chk("R10 done holds", {31'd0, done}, 32'd1);
  endtask

  task automatic t_preserve();
    resp_lat = 1;
    set_model(8'h5F, 8'h2D, 8'h01, 8'h00, 8'h00, 8'h00);
    run_seq("preserve");
    chk("R4 top bits kept", {16'd0, log_wdata[1]}, 32'h0000_2D68);
    chk("R8 latency from readback", {27'd0, rd_lat_cycles}, 32'd10);
    chk("R7 size 4MiB", size_bytes, 32'h0040_0000);
  endtask

  task automatic t_vendor_bad();
    resp_lat = 3;
    set_model(8'h00, 8'h0C, 8'h03, 8'h00, 8'h00, 8'h00);
    run_seq("vendor");
    chk("R6 absent", {31'd0, present}, 32'd0);
    chk("R6 size zero", size_bytes, 32'd0);
    chk("R6 stops after readback 0", req_cnt, 32'd3);
  endtask

  task automatic t_density();
    for (int c = 0; c < 8; c++) begin
      resp_lat = 1 + (c % 3);
      set_model(8'h00, 8'h0D, {5'b10000, 3'(c)}, 8'h00, 8'h00, 8'h00);
      run_seq("density");
      chk($sformatf("R7 density code %0d", c), size_bytes, exp_size(3'(c)));
      chk($sformatf("R6 present code %0d", c), {31'd0, present}, 32'd1);
    end
  endtask

  task automatic t_busy_start();
    int t;
    resp_lat = 4;
    set_model(8'h00, 8'h0D, 8'h05, 8'h00, 8'h00, 8'h00);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (7) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    chk("R2 start while busy ignored", req_cnt, 32'd6);
    chk("R7 size 16MiB", size_bytes, 32'h0100_0000);
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 9; i++) mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_stray();
    t_nominal();
    t_preserve();
    t_vendor_bad();
    t_density();
    t_busy_start();
    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule